// File: doc/BRIEF.md
# Six-Source Edge-Detecting Interrupt Controller

This block gathers six interrupt requests into one prioritised request for a small processor core. Three port pins are first synchronised into the core clock, and their falling edges raise three requests. The middle pin also raises a fourth, separate request on its rising edge. A software request strobe and a counter/timer request strobe supply the last two sources. Each event sets a sticky pending bit. The bit stays set until the core acknowledges that source, or until reset.

A seven-bit enable register gates the pending bits. It has one enable per source and one global enable that overrides all of them. The block compares enabled pending bits against a fixed priority, with source 0 highest. It presents the winner as a 3-bit index together with a valid flag. The core services the request and then pulses `ack` with the index it took, which clears that pending bit. The pending vector is also brought out, so the core can poll requests that are masked.

Top module: `intc6_edge`

## Requirements
- R1: After reset, every pending bit is 0, every enable is 0, and `irq_valid` is 0.
- R2: A high-to-low change on `pin_in[0]`, `pin_in[1]` or `pin_in[2]` sets pending bit 0, 1 or 2. The bit is visible after the (SYNC_STAGES+1)-th rising clock edge following the change, and not before. With the default of 2, that is the third edge.
- R3: A low-to-high change on `pin_in[1]` sets pending bit 3 with the same latency. Rising edges on `pin_in[0]` and `pin_in[2]` set no pending bit.
- R4: `sw_req` high at a rising edge sets pending bit 4. `tmr_req` high at a rising edge sets pending bit 5. The bit is visible after that edge.
- R5: A source event sets its pending bit whatever the enables are. A pending bit is cleared only by an acknowledge of its index or by reset.
- R6: `mask_wr` high at a rising edge loads `mask_wdata`. Bits 5:0 are the per-source enables, indexed by source number. Bit 6 is the global enable.
- R7: `irq_valid` is 1 exactly when bit 6 of the enable register is 1 and at least one pending bit has its per-source enable set.
- R8: While `irq_valid` is 1, `irq_idx` is the lowest source number whose pending bit and per-source enable are both set.
- R9: `ack` high at a rising edge with `ack_idx` below 6 clears that pending bit and leaves the others unchanged. An `ack_idx` of 6 or 7 changes nothing.
- R10: If a source event and an acknowledge of the same index fall on the same edge, the pending bit stays set.
- R11: A pin held at a constant level raises no further request. After the pending bit of that pin is acknowledged, it stays 0 until the pin changes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 3 | Asynchronous port pins, idle high |
| sw_req | input | 1 | Software request strobe (source 4) |
| tmr_req | input | 1 | Counter/timer request strobe (source 5) |
| mask_wr | input | 1 | Write strobe for the enable register |
| mask_wdata | input | 7 | New enables: bit 6 global, bits 5:0 per source |
| ack | input | 1 | Acknowledge strobe from the core |
| ack_idx | input | 3 | Index of the source being acknowledged |
| pend_o | output | 6 | Pending bits, indexed by source number |
| irq_valid | output | 1 | An enabled request is pending |
| irq_idx | output | 3 | Index of the highest-priority enabled request |

## Verification
The bench builds the block with its default parameters: two synchroniser stages and pins idle high. This makes the three-edge pin latency of R2 exact and countable. It also means a pin held high through reset raises no spurious edge. With these values, every edge, mask and acknowledge combination can be reached in a few cycles. Random pin toggles can therefore collide with acknowledges and mask writes, and they do so on the same edge many times during the run.

// File: rtl/intc6_edge.sv
module intc6_edge #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [2:0]  PIN_IDLE    = 3'b111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pin_in,
  input  logic       sw_req,
  input  logic       tmr_req,
  input  logic       mask_wr,
  input  logic [6:0] mask_wdata,
  input  logic       ack,
  input  logic [2:0] ack_idx,
  output logic [5:0] pend_o,
  output logic       irq_valid,
  output logic [2:0] irq_idx
);
  localparam int NSRC = 6;
  localparam int GEN  = NSRC;

  logic [SYNC_STAGES-1:0][2:0] sq;
  logic [2:0]      prev_q;
  logic [2:0]      pin_s;
  logic [NSRC-1:0] set_v, clr_v, pend_q, enab;
  logic [NSRC:0]   mask_q;

  assign pin_s = sq[SYNC_STAGES-1];
  assign set_v = {tmr_req, sw_req, ~prev_q[1] & pin_s[1], prev_q & ~pin_s};
  assign clr_v = (ack && ack_idx < 3'(NSRC)) ? NSRC'(1) << ack_idx : '0;
  assign enab  = pend_q & mask_q[NSRC-1:0] & {NSRC{mask_q[GEN]}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq     <= {SYNC_STAGES{PIN_IDLE}};
      prev_q <= PIN_IDLE;
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      if (SYNC_STAGES > 1) sq <= {sq[SYNC_STAGES-2:0], pin_in};
      else                 sq <= pin_in;
      prev_q <= pin_s;
      pend_q <= (pend_q & ~clr_v) | set_v;
      if (mask_wr) mask_q <= mask_wdata;
    end
  end

  always_comb begin
    irq_idx = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (enab[i]) irq_idx = 3'(i);
  end

  assign irq_valid = |enab;
  assign pend_o    = pend_q;
endmodule

// File: rtl/intc6_edge_chk.sv
module intc6_edge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic [2:0] ack_idx,
  input logic       sw_req,
  input logic       tmr_req,
  input logic [5:0] pend,
  input logic [6:0] mask,
  input logic [5:0] set_v,
  input logic       irq_valid,
  input logic [2:0] irq_idx
);
  logic [5:0] en_pend;
  assign en_pend = pend & mask[5:0];

  p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_idx < 3'd6);

  p_valid_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (mask[6] && en_pend[irq_idx]));

  p_global_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mask[6] |-> !irq_valid);

  p_no_higher_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (en_pend & ((6'd1 << irq_idx) - 6'd1)) == 6'd0);

  p_sw_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> pend[4]);

  p_tmr_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_req |=> pend[5]);

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_idx < 3'd6) |=> pend[$past(ack_idx)] == $past(set_v[ack_idx]));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ($past(pend) & ~pend) == 6'd0);
endmodule

bind intc6_edge intc6_edge_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ack(ack), .ack_idx(ack_idx),
  .sw_req(sw_req), .tmr_req(tmr_req), .pend(pend_q), .mask(mask_q),
  .set_v(set_v), .irq_valid(irq_valid), .irq_idx(irq_idx)
);

// File: tb/intc6_edge_tb_top.sv
`timescale 1ns/1ps
module intc6_edge_tb_top;
  localparam int S = 2;

  logic clk = 0, rst_n = 0;
  logic [2:0] pin_in = 3'b111;
  logic sw_req = 0, tmr_req = 0, mask_wr = 0, ack = 0;
  logic [6:0] mask_wdata = '0;
  logic [2:0] ack_idx = '0;
  wire  [5:0] pend_o;
  wire        irq_valid;
  wire  [2:0] irq_idx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intc6_edge #(.SYNC_STAGES(S), .PIN_IDLE(3'b111)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sw_req(sw_req), .tmr_req(tmr_req),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .ack(ack), .ack_idx(ack_idx),
    .pend_o(pend_o), .irq_valid(irq_valid), .irq_idx(irq_idx));

  // reference model built from the requirements
  logic [2:0] m_dl [S];
  logic [2:0] m_prev;
  logic [5:0] m_pend, m_set, m_clr;
  logic [6:0] m_mask;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < S; i++) m_dl[i] = 3'b111;
      m_prev = 3'b111; m_pend = '0; m_mask = '0;
    end else begin
      m_set = {tmr_req, sw_req, ~m_prev[1] & m_dl[S-1][1], m_prev & ~m_dl[S-1]};
      m_clr = (ack && ack_idx < 3'd6) ? (6'd1 << ack_idx) : 6'd0;
      m_pend = (m_pend & ~m_clr) | m_set;
      m_prev = m_dl[S-1];
      for (int i = S-1; i > 0; i--) m_dl[i] = m_dl[i-1];
      m_dl[0] = pin_in;
      if (mask_wr) m_mask = mask_wdata;
    end
  end

  function automatic bit exp_valid(input logic [5:0] p, input logic [6:0] m);
    return m[6] && ((p & m[5:0]) != 0);
  endfunction

  function automatic logic [2:0] exp_idx(input logic [5:0] p, input logic [6:0] m);
    for (int i = 0; i < 6; i++) if (p[i] && m[i]) return 3'(i);
    return 3'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp(input string req);
    chk(pend_o == m_pend, req, "pending", pend_o, m_pend);
    chk(irq_valid == exp_valid(m_pend, m_mask), req, "valid", irq_valid, exp_valid(m_pend, m_mask));
    if (exp_valid(m_pend, m_mask))
      chk(irq_idx == exp_idx(m_pend, m_mask), req, "index", irq_idx, exp_idx(m_pend, m_mask));
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr_mask(input logic [6:0] v);
    mask_wr = 1; mask_wdata = v; cyc(); mask_wr = 0;
  endtask

  task automatic do_ack(input logic [2:0] i);
    ack = 1; ack_idx = i; cyc(); ack = 0;
  endtask

  initial begin
    logic [5:0] snap;
    void'($urandom(32'd1925));
    cyc(3);
    // R1
    chk(pend_o == 0, "R1", "pending after reset", pend_o, 0);
    chk(irq_valid == 0, "R1", "valid after reset", irq_valid, 0);
    rst_n = 1;
    cyc(2);
    cmp("R1");

    // R2 latency on pin 0
    pin_in[0] = 0;
    cyc(2);
    chk(pend_o[0] == 0, "R2", "pin0 too early", pend_o[0], 0);
    cyc();
    chk(pend_o[0] == 1, "R2", "pin0 at third edge", pend_o[0], 1);
    // R5 latched while masked
    chk(irq_valid == 0, "R5", "masked valid", irq_valid, 0);
    // R6 enable all
    wr_mask(7'h7F);
    chk(irq_valid == 1 && irq_idx == 0, "R6", "enabled idx", irq_idx, 0);
    cmp("R6");

    // R3 pin1 fall then rise, pin0 rise ignored
    pin_in[1] = 0; cyc(4);
    chk(pend_o[1] == 1, "R2", "pin1 fall", pend_o[1], 1);
    pin_in[1] = 1; cyc(4);
    chk(pend_o[3] == 1, "R3", "pin1 rise", pend_o[3], 1);
    do_ack(3'd0); cyc();
    snap = pend_o;
    pin_in[0] = 1; cyc(4);
    chk(pend_o == snap, "R3", "pin0 rise ignored", pend_o, snap);
    cmp("R3");

    // R4
    sw_req = 1; cyc(); sw_req = 0;
    chk(pend_o[4] == 1, "R4", "sw", pend_o[4], 1);
    tmr_req = 1; cyc(); tmr_req = 0;
    chk(pend_o[5] == 1, "R4", "timer", pend_o[5], 1);

    // R8 priority walk with per-source masks
    wr_mask(7'b1_110101);
    chk(irq_idx == 3'd2 || !pend_o[2], "R8", "skip masked", irq_idx, 2);
    cmp("R8");
    do_ack(3'd1);
    cmp("R8");
    do_ack(3'd3); cmp("R8");

    // R9 invalid index
    snap = pend_o;
    do_ack(3'd6);
    chk(pend_o == snap, "R9", "ack idx 6", pend_o, snap);
    do_ack(3'd7);
    chk(pend_o == snap, "R9", "ack idx 7", pend_o, snap);
    do_ack(3'd5);
    chk(pend_o == (snap & ~6'h20), "R9", "ack idx 5", pend_o, snap & ~6'h20);

    // R10 collision
    sw_req = 1; ack = 1; ack_idx = 3'd4; cyc(); sw_req = 0; ack = 0;
    chk(pend_o[4] == 1, "R10", "set beats clear", pend_o[4], 1);

    // R11 held low pin
    pin_in[2] = 0; cyc(4);
    do_ack(3'd2); cyc(6);
    chk(pend_o[2] == 0, "R11", "no retrigger", pend_o[2], 0);
    pin_in[2] = 1; cyc(4);

    // R7 global off
    wr_mask(7'h3F);
    chk(irq_valid == 0, "R7", "global off", irq_valid, 0);
    cmp("R7");
    wr_mask(7'h7F);

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(7) == 0) pin_in[$urandom_range(2)] ^= 1'b1;
      sw_req  = ($urandom_range(15) == 0);
      tmr_req = ($urandom_range(15) == 0);
      mask_wr = ($urandom_range(31) == 0);
      mask_wdata = 7'($urandom);
      ack = ($urandom_range(3) == 0);
      ack_idx = ($urandom_range(3) == 0) ? 3'($urandom) : irq_idx;
      cyc();
      cmp("R8");
    end
    sw_req = 0; tmr_req = 0; mask_wr = 0; ack = 0;
    cyc(2);
    cmp("R5");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule